// File: doc/BRIEF.md
# Hierarchical SMI Status Aggregator

This block gathers the causes of system-management interrupts from an audio subsystem into one sticky second-level status word. There are three kinds of cause. Six DMA bus-master channels raise theirs when a page finishes. A codec raises its cause through a serial interrupt or a GPIO interrupt, and each of these has its own enable. An I/O trap detector raises a pulse. Once a status bit is set, it stays set until software clears it. While any bit is set, a single request line is held high, and that line feeds one bit of a top-level SMI status register.

Software can read the word through two views. The clearing view returns the word and clears every bit whose source has gone quiet. The mirror view returns the same word and clears nothing. Each channel holds a pending end-of-page flag. The flag is set by the DMA engine's page-done pulse and cleared by a separate write-one-to-clear strobe. A channel's status bit survives a clearing read for as long as that channel's flag is still pending, so the flag must be cleared first.

Top module: `smi_status_agg`

## Requirements
- R1: Status bit mapping: bit 0 is the I/O trap cause, bit 1 is the codec cause, and bits 2 to 7 are channels 0 to 5 in ascending order.
- R2: Bits 15:8 of every read return zero.
- R3: A channel sets its status bit only when its enable is 1 in the cycle its end-of-page flag goes from 0 to 1. A page-done pulse that arrives while the flag is already pending, or while the enable is 0, sets nothing.
- R4: The codec serial interrupt, when its enable is 1, sets bit 1. The codec GPIO interrupt, when its enable is 1, also sets bit 1. A codec interrupt whose own enable is 0 sets nothing.
- R5: A mirror read (`rd_mirror`=1, `rd_clear`=0) returns the status word and leaves every bit unchanged.
- R6: A channel's status bit is not cleared by a clearing read while that channel's end-of-page flag is still pending, and this includes the cycle in which the flag's clear strobe is applied.
- R7: A clearing read (`rd_clear`=1) returns the word as it stood before the read. It then clears every bit whose source is inactive: the trap bit always, the codec bit when no enabled codec interrupt is active, and a channel bit when its flag is not pending. When both read strobes are high, the clearing read takes effect.
- R8: A new event in the same cycle as a clearing read leaves its bit set.
- R9: `smi_req` is 1 exactly when at least one status bit is set, and it is aligned with the status word.
- R10: Synchronous reset clears the status word, all end-of-page flags, `rd_data`, `rd_valid` and `smi_req`.
- R11: A channel's end-of-page flag is set by `ch_eop_set` and cleared by `ch_eop_clr`. When both are high in the same cycle, set wins.
- R12: A read result appears on `rd_data` together with `rd_valid`=1 one cycle after the read strobe. `rd_data` holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | NUM_CH | Per-channel SMI enable |
| ch_eop_set | input | NUM_CH | Page-done pulse from each DMA engine |
| ch_eop_clr | input | NUM_CH | Write-one-to-clear strobe for each end-of-page flag |
| codec_ser_irq | input | 1 | Codec serial interrupt level |
| codec_ser_en | input | 1 | Enable for the serial interrupt cause |
| codec_gpio_irq | input | 1 | Codec GPIO interrupt level |
| codec_gpio_en | input | 1 | Enable for the GPIO interrupt cause |
| io_trap | input | 1 | I/O trap event pulse |
| rd_clear | input | 1 | Read strobe for the clearing view |
| rd_mirror | input | 1 | Read strobe for the non-clearing mirror view |
| rd_data | output | DATA_W | Registered read result |
| rd_valid | output | 1 | High for one cycle when rd_data is new |
| eop_pending | output | NUM_CH | Current end-of-page flags |
| smi_req | output | 1 | Summary bit to the top-level SMI status register |

## Verification
The bench applies a channel's flag-clear strobe in the same cycle as a clearing read. A design that sampled the flag after it had been updated would drop the status bit one step too early. It sends a page-done pulse to a flag that is already pending, which a design that detected a level rather than an edge would turn into a fresh SMI. It raises a trap in the same cycle as a clearing read, where a design that gave the clear priority would lose the event. It also checks that mirror reads, including a mirror read while a codec source is still active, leave the word and the request line untouched.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;
  localparam int TRAP_BIT  = 0;
  localparam int CODEC_BIT = 1;
  localparam int CH_BASE   = 2;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_MIRROR = 2'd1,
    RD_CLEAR  = 2'd2
  } rd_kind_e;

  function automatic rd_kind_e decode_read(input logic clr, input logic mir);
    if (clr)      return RD_CLEAR;
    else if (mir) return RD_MIRROR;
    else          return RD_NONE;
  endfunction
endpackage

// File: rtl/smi_eop_flags.sv
module smi_eop_flags #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] flag_q,
  output logic [NUM_CH-1:0] rise_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
    // set has priority over the write-one-to-clear strobe
    always_ff @(posedge clk) begin
      if (rst) flag_q[c] <= 1'b0;
      else     flag_q[c] <= set_i[c] | (flag_q[c] & ~clr_i[c]);
    end
    // an edge only: a pulse onto an already pending flag is not new
    assign rise_o[c] = set_i[c] & ~flag_q[c];
  end
endmodule

// File: rtl/smi_src_cond.sv
module smi_src_cond
  import smi_agg_pkg::*;
#(
  parameter int NUM_CH = 6,
  localparam int STAT_W = CH_BASE + NUM_CH
) (
  input  logic              trap_i,
  input  logic              ser_irq_i,
  input  logic              ser_en_i,
  input  logic              gpio_irq_i,
  input  logic              gpio_en_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] ch_rise_i,
  input  logic [NUM_CH-1:0] ch_flag_i,
  output logic [STAT_W-1:0] set_o,
  output logic [STAT_W-1:0] hold_o
);
  logic codec_act;
  assign codec_act = (ser_irq_i & ser_en_i) | (gpio_irq_i & gpio_en_i);

  assign set_o[TRAP_BIT]   = trap_i;
  assign hold_o[TRAP_BIT]  = 1'b0;
  assign set_o[CODEC_BIT]  = codec_act;
  assign hold_o[CODEC_BIT] = codec_act;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign set_o[CH_BASE+c]  = ch_en_i[c] & ch_rise_i[c];
    assign hold_o[CH_BASE+c] = ch_flag_i[c];
  end
endmodule

// File: rtl/smi_stat_reg.sv
module smi_stat_reg
  import smi_agg_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_kind_e          rd_kind_i,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] hold_i,
  output logic [STAT_W-1:0] stat_q,
  output logic              req_q
);
  logic [STAT_W-1:0] stat_d;
  logic              clr_rd;

  assign clr_rd = (rd_kind_i == RD_CLEAR);

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    logic drop;
    assign drop      = clr_rd & ~hold_i[b];
    assign stat_d[b] = set_i[b] | (stat_q[b] & ~drop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      req_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      req_q  <= |stat_d;
    end
  end
endmodule

// File: rtl/smi_read_port.sv
module smi_read_port
  import smi_agg_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_kind_e          rd_kind_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [DATA_W-1:0] rd_data_q,
  output logic              rd_valid_q
);
  localparam int PAD_W = DATA_W - STAT_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= (rd_kind_i != RD_NONE);
      if (rd_kind_i != RD_NONE) rd_data_q <= {{PAD_W{1'b0}}, stat_i};
    end
  end
endmodule

// File: rtl/smi_status_agg.sv
module smi_status_agg
  import smi_agg_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_eop_set,
  input  logic [NUM_CH-1:0] ch_eop_clr,
  input  logic              codec_ser_irq,
  input  logic              codec_ser_en,
  input  logic              codec_gpio_irq,
  input  logic              codec_gpio_en,
  input  logic              io_trap,
  input  logic              rd_clear,
  input  logic              rd_mirror,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [NUM_CH-1:0] eop_pending,
  output logic              smi_req
);
  localparam int STAT_W = CH_BASE + NUM_CH;

  logic [NUM_CH-1:0] ch_rise;
  logic [STAT_W-1:0] set_vec, hold_vec, stat_q;
  rd_kind_e          rd_kind;

  assign rd_kind = decode_read(rd_clear, rd_mirror);

  smi_eop_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst(rst), .set_i(ch_eop_set), .clr_i(ch_eop_clr),
    .flag_q(eop_pending), .rise_o(ch_rise)
  );

  smi_src_cond #(.NUM_CH(NUM_CH)) u_cond (
    .trap_i(io_trap), .ser_irq_i(codec_ser_irq), .ser_en_i(codec_ser_en),
    .gpio_irq_i(codec_gpio_irq), .gpio_en_i(codec_gpio_en),
    .ch_en_i(ch_en), .ch_rise_i(ch_rise), .ch_flag_i(eop_pending),
    .set_o(set_vec), .hold_o(hold_vec)
  );

  smi_stat_reg #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst(rst), .rd_kind_i(rd_kind), .set_i(set_vec),
    .hold_i(hold_vec), .stat_q(stat_q), .req_q(smi_req)
  );

  smi_read_port #(.STAT_W(STAT_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_kind_i(rd_kind), .stat_i(stat_q),
    .rd_data_q(rd_data), .rd_valid_q(rd_valid)
  );
endmodule

// File: rtl/smi_status_agg_chk.sv
module smi_status_agg_chk #(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 16,
  localparam int STAT_W = 2 + NUM_CH
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] ch_eop_set,
  input logic              io_trap,
  input logic              rd_clear,
  input logic              rd_mirror,
  input logic [DATA_W-1:0] rd_data,
  input logic [NUM_CH-1:0] eop_pending,
  input logic [STAT_W-1:0] stat_q,
  input logic              smi_req
);
  // R2
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:STAT_W] == '0);

  p_mirror_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_mirror && !rd_clear) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_trap_wins_r8: assert property (@(posedge clk) disable iff (rst)
    io_trap |=> stat_q[0]);

  p_req_summary_r9: assert property (@(posedge clk) disable iff (rst)
    smi_req == (stat_q != '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_hold_pending_r6: assert property (@(posedge clk) disable iff (rst)
      (eop_pending[c] && stat_q[2+c]) |=> stat_q[2+c]);

    p_no_set_disabled_r3: assert property (@(posedge clk) disable iff (rst)
      (!stat_q[2+c] && !ch_en[c]) |=> !stat_q[2+c]);

    p_flag_set_r11: assert property (@(posedge clk) disable iff (rst)
      ch_eop_set[c] |=> eop_pending[c]);
  end
endmodule

bind smi_status_agg smi_status_agg_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ch_en(ch_en), .ch_eop_set(ch_eop_set),
  .io_trap(io_trap), .rd_clear(rd_clear), .rd_mirror(rd_mirror),
  .rd_data(rd_data), .eop_pending(eop_pending), .stat_q(stat_q),
  .smi_req(smi_req)
);

// File: tb/smi_status_agg_tb.sv
module smi_status_agg_tb;
  localparam int NCH = 6;
  localparam int DW  = 16;
  localparam int NV  = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] ch_en = '0, ch_eop_set = '0, ch_eop_clr = '0;
  logic ser_irq = 0, ser_en = 0, gpio_irq = 0, gpio_en = 0, trap = 0;
  logic rd_clear = 0, rd_mirror = 0;
  logic [DW-1:0]  rd_data;
  logic           rd_valid, smi_req;
  logic [NCH-1:0] eop_pending;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  smi_status_agg #(.NUM_CH(NCH), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .ch_en(ch_en), .ch_eop_set(ch_eop_set),
    .ch_eop_clr(ch_eop_clr), .codec_ser_irq(ser_irq), .codec_ser_en(ser_en),
    .codec_gpio_irq(gpio_irq), .codec_gpio_en(gpio_en), .io_trap(trap),
    .rd_clear(rd_clear), .rd_mirror(rd_mirror), .rd_data(rd_data),
    .rd_valid(rd_valid), .eop_pending(eop_pending), .smi_req(smi_req)
  );

  // fields: en[33:28] set[27:22] clr[21:16] {ser_irq,ser_en,gpio_irq,gpio_en}[15:12]
  //         trap[11] rd_clear[10] rd_mirror[9] exp_rd[8:1] exp_req[0]
  localparam logic [33:0] VEC [NV] = '{
    {6'b000000,6'b000000,6'b000000,4'b0000,1'b1,1'b0,1'b0,8'h00,1'b1}, // R1 trap
    {6'b000000,6'b000000,6'b000000,4'b0000,1'b0,1'b0,1'b1,8'h01,1'b1}, // R5
    {6'b000000,6'b000000,6'b000000,4'b0000,1'b0,1'b1,1'b0,8'h01,1'b0}, // R7
    {6'b000001,6'b000001,6'b000000,4'b0000,1'b0,1'b0,1'b0,8'h00,1'b1}, // R3 ch0
    {6'b000000,6'b000000,6'b000000,4'b0000,1'b0,1'b1,1'b0,8'h04,1'b1}, // R6
    {6'b000000,6'b000000,6'b000001,4'b0000,1'b0,1'b1,1'b0,8'h04,1'b1}, // R6 same cycle
    {6'b000000,6'b000000,6'b000000,4'b0000,1'b0,1'b1,1'b0,8'h04,1'b0}, // R7
    {6'b000000,6'b000010,6'b000000,4'b0000,1'b0,1'b0,1'b0,8'h00,1'b0}, // R3 disabled
    {6'b000000,6'b000000,6'b000000,4'b0000,1'b0,1'b0,1'b1,8'h00,1'b0},
    {6'b000010,6'b000010,6'b000000,4'b0000,1'b0,1'b0,1'b0,8'h00,1'b0}, // R3 no edge
    {6'b000000,6'b000000,6'b000010,4'b0000,1'b0,1'b0,1'b0,8'h00,1'b0},
    {6'b100000,6'b100000,6'b000000,4'b1000,1'b0,1'b0,1'b0,8'h00,1'b1}, // R4 ser off
    {6'b000000,6'b000000,6'b100000,4'b0011,1'b0,1'b0,1'b0,8'h00,1'b1}, // R4 gpio
    {6'b000000,6'b000000,6'b000000,4'b0011,1'b0,1'b1,1'b0,8'h82,1'b1}, // R7 codec held
    {6'b000000,6'b000000,6'b000000,4'b0000,1'b0,1'b1,1'b0,8'h02,1'b0},
    {6'b000000,6'b000000,6'b000000,4'b0000,1'b1,1'b1,1'b0,8'h00,1'b1}, // R8
    {6'b000000,6'b000000,6'b000000,4'b1100,1'b0,1'b1,1'b0,8'h01,1'b1}, // R4 ser, R8
    {6'b000000,6'b000000,6'b000000,4'b0000,1'b0,1'b1,1'b0,8'h02,1'b0},
    {6'b011100,6'b011100,6'b000000,4'b0000,1'b0,1'b0,1'b0,8'h00,1'b1}, // R1 ch2-4
    {6'b000000,6'b000000,6'b011100,4'b0000,1'b0,1'b0,1'b0,8'h00,1'b1},
    {6'b000000,6'b000000,6'b000000,4'b0000,1'b0,1'b0,1'b1,8'h70,1'b1}, // R5
    {6'b000000,6'b000000,6'b000000,4'b0000,1'b0,1'b1,1'b0,8'h70,1'b0}  // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ch_en = '0; ch_eop_set = '0; ch_eop_clr = '0;
    {ser_irq, ser_en, gpio_irq, gpio_en} = 4'b0;
    trap = 0; rd_clear = 0; rd_mirror = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 0;
    // R10 reset state
    chk("R10 rd_data", 32'(rd_data), 0);
    chk("R10 rd_valid", 32'(rd_valid), 0);
    chk("R10 smi_req", 32'(smi_req), 0);
    chk("R10 eop_pending", 32'(eop_pending), 0);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      ch_en = v[33:28]; ch_eop_set = v[27:22]; ch_eop_clr = v[21:16];
      {ser_irq, ser_en, gpio_irq, gpio_en} = v[15:12];
      trap = v[11]; rd_clear = v[10]; rd_mirror = v[9];
      step();
      idle_inputs();
      chk($sformatf("R9 smi_req vec %0d", i), 32'(smi_req), 32'(v[0]));
      chk($sformatf("R12 rd_valid vec %0d", i), 32'(rd_valid), 32'(v[10] | v[9]));
      if (v[10] | v[9]) begin
        chk($sformatf("R7 rd_data vec %0d", i), 32'(rd_data[7:0]), 32'(v[8:1]));
        chk($sformatf("R2 reserved vec %0d", i), 32'(rd_data[15:8]), 0);
      end
    end

    // R12 rd_data holds without a read
    step();
    chk("R12 hold rd_data", 32'(rd_data), 32'h70);

    // R11 set and clear in the same cycle: set wins
    ch_eop_set = 6'b001000; ch_eop_clr = 6'b001000;
    step(); idle_inputs();
    chk("R11 set beats clr", 32'(eop_pending), 32'h08);
    ch_eop_clr = 6'b001000;
    step(); idle_inputs();
    chk("R11 clr", 32'(eop_pending), 0);
    chk("R3 disabled edge no smi", 32'(smi_req), 0);

    // R4 codec with enable off on both sources sets nothing; mirror confirms
    {ser_irq, ser_en, gpio_irq, gpio_en} = 4'b1010; rd_mirror = 1;
    step(); idle_inputs();
    rd_mirror = 1;
    step(); idle_inputs();
    chk("R4 disabled codec", 32'(rd_data), 0);

    // R5 both strobes: clearing read wins (R7)
    trap = 1;
    step(); idle_inputs();
    rd_clear = 1; rd_mirror = 1;
    step(); idle_inputs();
    chk("R7 both strobes data", 32'(rd_data), 1);
    chk("R7 both strobes cleared", 32'(smi_req), 0);

    // R10 reset mid-activity
    trap = 1; ch_en = 6'b000001; ch_eop_set = 6'b000001;
    step(); idle_inputs();
    rst = 1;
    step();
    rst = 0;
    chk("R10 mid reset smi_req", 32'(smi_req), 0);
    chk("R10 mid reset eop", 32'(eop_pending), 0);
    rd_mirror = 1;
    step(); idle_inputs();
    chk("R10 mid reset status", 32'(rd_data), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule